// File: doc/BRIEF.md
# Delayed One-Shot Pulse Timer with Trigger Capture

This block is one timer channel. A 16-bit up-counter runs freely and advances only when the prescaler tick input is high. It is never cleared. A rising edge on the external trigger input stores the counter value in a capture register. In the same cycle the block computes two compare values in hardware: capture plus delay, and capture plus delay plus width. The output flip-flop toggles when the counter reaches each compare value. The two toggles make exactly one high pulse on the output pin. The pulse starts `delay` ticks after the captured count and lasts `width` ticks.

The channel is prepared with the arm input. Arming sets both toggle enables and drives the output low. After arming, the first synchronised trigger edge launches a pulse. Trigger edges that come later are ignored for pulse generation until the channel is armed again. The second compare match raises a completion strobe and clears the toggle enables. Later matches, after the counter wraps, cannot disturb the output. A second capture register records the counter on every trigger edge, including ignored ones. Every trigger edge also produces an event strobe.

All compare arithmetic wraps modulo 2^16, so a pulse that crosses counter rollover is placed correctly. For correct placement the delay must be at least 1 and the sum of delay and width must stay below 2^16.

Top module: `oneshot_capture_timer`

## Requirements
- R1: After reset the output pulse is low, both capture values are 0, both strobes are low and the channel is disarmed. A trigger edge before the first arm leaves capture register 0 at 0.
- R2: The counter advances by one per clock cycle in which the tick is high, holds otherwise, wraps from 0xFFFF to 0 and is never cleared. It is observed through the capture values.
- R3: The trigger is synchronised through two flip-flops and edge-detected. Each rising edge produces exactly one one-cycle event strobe. When the channel is armed and no pulse has been launched, the same edge stores the counter in capture register 0.
- R4: Every synchronised rising trigger edge stores the counter in capture register 1, whether or not it is accepted.
- R5: The output rises on the counter advance to capture0 + delay and falls on the advance to capture0 + delay + width. Both sums are taken modulo 2^16. The output toggles one clock cycle after the tick that reaches the compare value.
- R6: The end match raises a one-cycle completion strobe in the same cycle the output falls, and clears the toggle enables. No further toggles or captures into register 0 happen until the next arm.
- R7: A trigger edge that arrives while a pulse is pending or in progress does not change capture register 0 or the pulse timing.
- R8: A match toggles the output once only. If the counter stays on a compare value while no tick arrives, the output does not toggle again.
- R9: A trigger held high for many cycles counts as a single edge.
- R10: A pulse whose compare values wrap past 0xFFFF has the same delay and width as any other pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler tick; counter advances when high |
| trig_i | input | 1 | External trigger, asynchronous, active high |
| arm_i | input | 1 | Sets both toggle enables and clears the output |
| delay_i | input | 16 | Ticks from capture to pulse start |
| width_i | input | 16 | Pulse length in ticks |
| pulse_o | output | 1 | One-shot pulse output |
| trig_evt_o | output | 1 | One-cycle strobe per trigger edge |
| done_irq_o | output | 1 | One-cycle strobe at the end match |
| cap0_o | output | 16 | Counter value at the accepted trigger |
| cap1_o | output | 16 | Counter value at the latest trigger edge |

## Verification
A wrong capture or a wrong compare sum shows up as a pulse edge moved by some number of ticks. It appears at the first tick where the bench's expected level differs, so the bench checks the output level after every tick. An enable bit that fails to clear shows up after the counter wraps, as a second pulse or a repeated completion strobe. An acceptance flag that is wrongly set shows up as a change in capture register 0 within three clock cycles of a trigger that should have been ignored. A match that fires more than once shows up as the output flipping while the tick is held low.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  // Leading-edge compare value: capture + delay, modulo 2^CNT_W.
  function automatic cnt_t lead_point(input cnt_t cap, input cnt_t dly);
    return cnt_t'(cap + dly);
  endfunction

  // Trailing-edge compare value: leading point + width, modulo 2^CNT_W.
  function automatic cnt_t trail_point(input cnt_t cap, input cnt_t dly, input cnt_t wid);
    return cnt_t'(lead_point(cap, dly) + wid);
  endfunction
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], trig_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ost_counter.sv
module ost_counter
  import ost_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output cnt_t cnt_o,
  output logic adv_o
);
  cnt_t cnt_q;
  logic adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= tick_i;
      if (tick_i) cnt_q <= cnt_t'(cnt_q + 1'b1);
    end
  end

  assign cnt_o = cnt_q;
  assign adv_o = adv_q;
endmodule

// File: rtl/ost_channel.sv
module ost_channel
  import ost_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic arm_i,
  input  cnt_t cnt_i,
  input  logic adv_i,
  input  cnt_t delay_i,
  input  cnt_t width_i,
  output logic pulse_o,
  output logic trig_evt_o,
  output logic done_irq_o,
  output cnt_t cap0_o,
  output cnt_t cap1_o,
  output logic en_all_o
);
  localparam int unsigned NCMP = 2;

  logic [1:0]      en_q;
  logic            launched_q;
  logic            pulse_q;
  logic            evt_q;
  logic            irq_q;
  cnt_t            cap0_q;
  cnt_t            cap1_q;
  cnt_t            cmp_q [NCMP];
  logic [NCMP-1:0] match;
  logic            live;
  logic            accept;

  assign live   = launched_q & (&en_q);
  assign accept = rise_i & (&en_q) & ~launched_q;

  // One match strobe per compare register, valid only on an advance cycle.
  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign match[i] = adv_i & live & (cnt_i == cmp_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 2'b00;
      launched_q <= 1'b0;
      pulse_q    <= 1'b0;
      evt_q      <= 1'b0;
      irq_q      <= 1'b0;
      cap0_q     <= '0;
      cap1_q     <= '0;
      cmp_q[0]   <= '0;
      cmp_q[1]   <= '0;
    end else begin
      evt_q <= rise_i;
      irq_q <= match[1];
      if (rise_i) cap1_q <= cnt_i;
      if (arm_i) begin
        en_q       <= 2'b11;
        launched_q <= 1'b0;
        pulse_q    <= 1'b0;
      end else begin
        if (accept) begin
          launched_q <= 1'b1;
          cap0_q     <= cnt_i;
          cmp_q[0]   <= lead_point(cnt_i, delay_i);
          cmp_q[1]   <= trail_point(cnt_i, delay_i, width_i);
        end
        pulse_q <= pulse_q ^ match[0] ^ match[1];
        if (match[1]) en_q <= 2'b00;
      end
    end
  end

  assign pulse_o    = pulse_q;
  assign trig_evt_o = evt_q;
  assign done_irq_o = irq_q;
  assign cap0_o     = cap0_q;
  assign cap1_o     = cap1_q;
  assign en_all_o   = &en_q;
endmodule

// File: rtl/oneshot_capture_timer.sv
module oneshot_capture_timer
  import ost_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             trig_evt_o,
  output logic             done_irq_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o
);
  cnt_t cnt;
  logic cnt_adv;
  logic trig_rise;
  logic en_all;

  ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  ost_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .adv_o  (cnt_adv)
  );

  ost_channel u_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (trig_rise),
    .arm_i      (arm_i),
    .cnt_i      (cnt),
    .adv_i      (cnt_adv),
    .delay_i    (delay_i),
    .width_i    (width_i),
    .pulse_o    (pulse_o),
    .trig_evt_o (trig_evt_o),
    .done_irq_o (done_irq_o),
    .cap0_o     (cap0_o),
    .cap1_o     (cap1_o),
    .en_all_o   (en_all)
  );
endmodule

// File: rtl/ost_checker.sv
module ost_checker
  import ost_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input cnt_t cnt,
  input logic cnt_adv,
  input logic en_all,
  input logic pulse_o,
  input logic trig_evt_o,
  input logic done_irq_o
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt == cnt_t'($past(cnt) + 1'b1)));

  // R8
  toggle_needs_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != $past(pulse_o)) && $past(en_all) |-> $past(cnt_adv));

  // R6
  no_toggle_disarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_all |=> (pulse_o == 1'b0 || $stable(pulse_o)));

  // R6
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);

  // R5
  irq_with_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> (!pulse_o && $past(pulse_o)));

  // R3
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_evt_o |=> !trig_evt_o);
endmodule

bind oneshot_capture_timer ost_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cnt        (cnt),
  .cnt_adv    (cnt_adv),
  .en_all     (en_all),
  .pulse_o    (pulse_o),
  .trig_evt_o (trig_evt_o),
  .done_irq_o (done_irq_o)
);

// File: tb/oneshot_capture_timer_tb.sv
module oneshot_capture_timer_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        trig = 1'b0;
  logic        arm = 1'b0;
  logic [15:0] delay = '0;
  logic [15:0] width = '0;
  logic        pulse, evt, irq;
  logic [15:0] cap0, cap1;

  int unsigned checks = 0;
  int unsigned fails = 0;
  int unsigned evt_cnt = 0;
  int unsigned irq_cnt = 0;
  logic [15:0] model = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_capture_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .trig_i(trig), .arm_i(arm),
    .delay_i(delay), .width_i(width), .pulse_o(pulse), .trig_evt_o(evt),
    .done_irq_o(irq), .cap0_o(cap0), .cap1_o(cap1)
  );

  always @(posedge clk) begin
    if (rst_ni && evt) evt_cnt++;
    if (rst_ni && irq) irq_cnt++;
  end

  function automatic bit exp_level(input int k, input int d, input int w);
    return (k >= d) && (k < d + w);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model = model + 16'd1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      model = model + 16'(n);
      @(negedge clk);
    end
  endtask

  task automatic fire_trig(input int hold);
    trig = 1'b1;
    repeat (hold) @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_shot(input int d, input int w, input bit retrig);
    int e0, i0;
    logic [15:0] c;
    delay = 16'(d);
    width = 16'(w);
    e0 = evt_cnt;
    c = model;
    fire_trig(6);
    // R9 long trigger level gives one event; R3 capture
    chk(evt_cnt == e0 + 1, "R9 event count", evt_cnt, e0 + 1);
    chk(cap0 == c, "R3 cap0", cap0, c);
    chk(cap1 == c, "R4 cap1", cap1, c);
    chk(pulse == 1'b0, "R5 low before delay", pulse, 0);
    i0 = irq_cnt;
    for (int k = 1; k <= d + w + 3; k++) begin
      step_tick();
      chk(pulse == exp_level(k, d, w), "R5 level", pulse, exp_level(k, d, w));
      chk(irq_cnt == i0 + ((k >= d + w) ? 1 : 0), "R6 irq", irq_cnt, i0 + ((k >= d + w) ? 1 : 0));
      if (k == d) begin
        repeat (8) @(negedge clk);
        // R8 no retoggle while counter rests on compare value
        chk(pulse == exp_level(k, d, w), "R8 hold", pulse, exp_level(k, d, w));
      end
      if (retrig && k == d) begin
        fire_trig(2);
        chk(cap0 == c, "R7 cap0 kept", cap0, c);
        chk(cap1 == model, "R4 cap1 on ignored edge", cap1, model);
      end
    end
    // R6 disarmed: trigger and further ticks do nothing
    c = model;
    fire_trig(2);
    chk(cap0 != c || d + w == 0, "R6 cap0 frozen", cap0, c - 1);
    for (int k = 0; k < 6; k++) begin
      step_tick();
      chk(pulse == 1'b0, "R6 no pulse while disarmed", pulse, 0);
    end
    chk(irq_cnt == i0 + 1, "R6 single irq", irq_cnt, i0 + 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pulse == 1'b0, "R1 pulse", pulse, 0);
    chk(cap0 == 16'd0, "R1 cap0", cap0, 0);
    chk(cap1 == 16'd0, "R1 cap1", cap1, 0);
    chk(evt == 1'b0 && irq == 1'b0, "R1 strobes", {evt, irq}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    run_ticks(5);
    fire_trig(2);
    chk(cap0 == 16'd0, "R1 disarmed cap0", cap0, 0);
    chk(cap1 == model, "R2 R4 cap1 count", cap1, model);
    chk(evt_cnt == 1, "R3 event", evt_cnt, 1);
    do_arm();
    do_shot(3, 4, 1'b0);
    do_arm();
    do_shot(1, 1, 1'b0);
    for (int t = 0; t < 5; t++) begin
      int d, w;
      d = 1 + int'($urandom_range(0, 149));
      w = 2 + int'($urandom_range(0, 149));
      run_ticks(int'($urandom_range(0, 40)));
      do_arm();
      do_shot(d, w, t[0]);
    end
    // R10 rollover: place capture near top of range
    run_ticks(int'(16'(16'hFFE8 - model)));
    chk(model == 16'hFFE8, "R2 preroll model", model, 16'hFFE8);
    do_arm();
    do_shot(12, 30, 1'b1);
    chk(cap0 == 16'hFFE8, "R10 wrap capture", cap0, 16'hFFE8);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule